// File: doc/BRIEF.md
# Power-Down Entry Guard

This block sits beside the command issue stage of a DDR3-style memory controller and decides the earliest cycle at which the clock-enable pin may be pulled low to put the memory into power-down. It watches each command slot. Every command that needs time to finish before power-down loads a countdown. The load value is worked out from the command type, the burst configuration, the auto-precharge variant and the static latency settings.

The controller raises a level request when it wants power-down. The guard grants entry in the first slot where three things hold: the countdown has run out, the slot carries a no-operation or deselect, and the request is high. In that same slot the guard drives clock-enable low. Clock-enable stays low for as long as the request stays high. Dropping the request raises clock-enable again. The exit timing that follows is left to the surrounding controller.

Command codes on `cmd_i`: 0 no-operation, 1 deselect, 2 activate, 3 precharge, 4 refresh, 5 read, 6 read with auto-precharge, 7 write, 8 write with auto-precharge, 9 mode-register set, 10 multipurpose-register read, 11 ZQ calibration. Codes 12 to 15 load nothing and are not idle slots. Burst codes on `cfg_burst_i`: 0 fixed length 8, 1 chosen per command (on the fly), 2 chop-4 fixed by the mode register, 3 treated like 0. A wait of N means that for a command in cycle c, the first slot that may carry entry is cycle c+N.

Top module: `pd_entry_guard`

## Requirements
- R1: A grant (and clock-enable low) occurs only in a slot whose command is code 0 or 1. With the request high and the wait expired, any other code holds the grant low and clock-enable high.
- R2: After an activate, precharge or refresh (codes 2, 3, 4) the wait is 1 cycle.
- R3: After a read, read with auto-precharge or multipurpose-register read (codes 5, 6, 10) the wait is read latency plus 5 cycles, whatever the burst code.
- R4: After a write (code 7) the wait is write latency plus write recovery plus 4 cycles. With burst code 2 the 4 becomes 2.
- R5: After a write with auto-precharge (code 8) the wait is write latency plus write recovery plus 5 cycles. With burst code 2 the 5 becomes 3.
- R6: After a mode-register set (code 9) the wait is the configured mode-register delay. After ZQ calibration (code 11) it is the configured ZQ duration.
- R7: A later command never shortens the wait left by an earlier one. The remaining wait becomes the larger of the two.
- R8: A request raised while the wait is running stays pending with no re-issue. Clock-enable stays high and the grant stays low until entry is allowed.
- R9: After entry, clock-enable stays low while the request stays high, and the grant pulses only in the entry slot. Dropping the request raises clock-enable in that same cycle.
- R10: While reset is active, and straight after it, clock-enable is high, the grant is low and no wait is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command in the current slot |
| cfg_burst_i | input | 2 | Burst configuration code |
| cfg_rl_i | input | LAT_W | Read latency in cycles |
| cfg_wl_i | input | LAT_W | Write latency in cycles |
| cfg_wr_i | input | LAT_W | Write recovery in cycles |
| cfg_tmod_i | input | LAT_W | Mode-register update delay in cycles |
| cfg_zq_i | input | ZQ_W | ZQ calibration duration in cycles |
| pd_req_i | input | 1 | Level request for power-down |
| pd_grant_o | output | 1 | High in the slot where entry happens |
| cke_o | output | 1 | Clock-enable drive to the memory |

## Verification
The hardest case to reach is two overlapping commands, where a short-wait command lands while a long read or write wait is still running. In that case only the larger-of rule stops entry from coming too early. The stimulus issues a read and then an activate in the very next slot, with the request already high. It then counts cycles from the read, so a design that reloads the activate's one-cycle wait shows up as entry 14 cycles too soon. The same measured wait loop keeps the request high through every long countdown, which checks that clock-enable never drops early.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_DES = 4'd1,
        CMD_ACT = 4'd2,
        CMD_PRE = 4'd3,
        CMD_REF = 4'd4,
        CMD_RD  = 4'd5,
        CMD_RDA = 4'd6,
        CMD_WR  = 4'd7,
        CMD_WRA = 4'd8,
        CMD_MRS = 4'd9,
        CMD_MPR = 4'd10,
        CMD_ZQ  = 4'd11
    } pdg_cmd_e;

    typedef enum logic [1:0] {
        BURST_FIX8    = 2'd0,
        BURST_OTF     = 2'd1,
        BURST_MRS_BC4 = 2'd2,
        BURST_RSVD    = 2'd3
    } pdg_burst_e;

    function automatic logic pdg_is_idle(input logic [3:0] c);
        return (c == CMD_NOP) || (c == CMD_DES);
    endfunction

endpackage

// File: rtl/pdg_delay_calc.sv
module pdg_delay_calc
    import pdg_pkg::*;
#(
    parameter int LAT_W = 5,
    parameter int ZQ_W  = 10,
    parameter int CNT_W = 11
) (
    input  logic [3:0]       cmd_i,
    input  logic [1:0]       burst_i,
    input  logic [LAT_W-1:0] rl_i,
    input  logic [LAT_W-1:0] wl_i,
    input  logic [LAT_W-1:0] wr_i,
    input  logic [LAT_W-1:0] tmod_i,
    input  logic [ZQ_W-1:0]  zq_i,
    output logic             load_o,
    output logic [CNT_W-1:0] wait_o
);

    logic [CNT_W-1:0] burst_x;
    logic [CNT_W-1:0] rl_x;
    logic [CNT_W-1:0] wl_x;
    logic [CNT_W-1:0] wr_x;
    logic [CNT_W-1:0] wrbase_x;

    always_comb begin
        burst_x  = (burst_i == BURST_MRS_BC4) ? CNT_W'(2) : CNT_W'(4);
        rl_x     = CNT_W'(rl_i);
        wl_x     = CNT_W'(wl_i);
        wr_x     = CNT_W'(wr_i);
        wrbase_x = wl_x + burst_x + wr_x;
        load_o   = 1'b1;
        wait_o   = CNT_W'(1);
        case (cmd_i)
            CMD_ACT, CMD_PRE, CMD_REF: wait_o = CNT_W'(1);
            CMD_RD, CMD_RDA, CMD_MPR:  wait_o = rl_x + CNT_W'(5);
            CMD_WR:                    wait_o = wrbase_x;
            CMD_WRA:                   wait_o = wrbase_x + CNT_W'(1);
            CMD_MRS:                   wait_o = CNT_W'(tmod_i);
            CMD_ZQ:                    wait_o = CNT_W'(zq_i);
            default: begin
                load_o = 1'b0;
                wait_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/pdg_countdown.sv
module pdg_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] wait_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic [CNT_W-1:0] dec_d;
    logic [CNT_W-1:0] cand_d;

    always_comb begin
        st_d   = st_q;
        dec_d  = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
        cand_d = (wait_i == '0) ? '0 : wait_i - CNT_W'(1);
        if (load_i && (cand_d > dec_d)) begin
            st_d.cnt = cand_d;
        end else begin
            st_d.cnt = dec_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign zero_o = (st_q.cnt == '0);

    // R7: an idle slot runs the count down by one each cycle
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // R7: a load never leaves less than the loaded wait
    p_load_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && wait_i != '0) |=> (st_q.cnt >= $past(wait_i) - CNT_W'(1)));

    // R7: a load never shortens what was left
    p_no_shorten_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && st_q.cnt != '0) |=> (st_q.cnt >= $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/pdg_entry_ctrl.sv
module pdg_entry_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_slot_i,
    input  logic wait_done_i,
    input  logic pd_req_i,
    output logic grant_o,
    output logic cke_o
);

    typedef struct packed {
        logic in_pd;
    } ec_state_t;

    ec_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        grant_o = rst_n && pd_req_i && !st_q.in_pd && idle_slot_i && wait_done_i;
        cke_o   = !(grant_o || (st_q.in_pd && pd_req_i));
        st_d.in_pd = pd_req_i && (st_q.in_pd || grant_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: the grant is a single pulse per entry
    p_grant_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && pd_req_i) |=> !grant_o);

    // R9: clock-enable stays low while the request is held
    p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && pd_req_i) |=> (!pd_req_i || !cke_o));

    // R1: clock-enable only falls on a granted slot
    p_fall_on_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> grant_o);

endmodule

// File: rtl/pd_entry_guard.sv
module pd_entry_guard
    import pdg_pkg::*;
#(
    parameter int LAT_W = 5,
    parameter int ZQ_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cmd_i,
    input  logic [1:0]       cfg_burst_i,
    input  logic [LAT_W-1:0] cfg_rl_i,
    input  logic [LAT_W-1:0] cfg_wl_i,
    input  logic [LAT_W-1:0] cfg_wr_i,
    input  logic [LAT_W-1:0] cfg_tmod_i,
    input  logic [ZQ_W-1:0]  cfg_zq_i,
    input  logic             pd_req_i,
    output logic             pd_grant_o,
    output logic             cke_o
);

    localparam int SUM_W = LAT_W + 2;
    localparam int CNT_W = ((SUM_W > ZQ_W) ? SUM_W : ZQ_W) + 1;

    logic             load_w;
    logic [CNT_W-1:0] wait_w;
    logic [CNT_W-1:0] cnt_w;
    logic             zero_w;
    logic             idle_w;

    assign idle_w = pdg_is_idle(cmd_i);

    pdg_delay_calc #(
        .LAT_W (LAT_W),
        .ZQ_W  (ZQ_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .cmd_i   (cmd_i),
        .burst_i (cfg_burst_i),
        .rl_i    (cfg_rl_i),
        .wl_i    (cfg_wl_i),
        .wr_i    (cfg_wr_i),
        .tmod_i  (cfg_tmod_i),
        .zq_i    (cfg_zq_i),
        .load_o  (load_w),
        .wait_o  (wait_w)
    );

    pdg_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .wait_i (wait_w),
        .cnt_o  (cnt_w),
        .zero_o (zero_w)
    );

    pdg_entry_ctrl u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_slot_i (idle_w),
        .wait_done_i (zero_w),
        .pd_req_i    (pd_req_i),
        .grant_o     (pd_grant_o),
        .cke_o       (cke_o)
    );

    // R1: entry only on a no-operation or deselect slot
    p_grant_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pd_grant_o |-> (cmd_i == CMD_NOP || cmd_i == CMD_DES));

    // R8: a running wait keeps clock-enable high
    p_wait_keeps_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w != '0) |-> (cke_o || (pd_req_i && !pd_grant_o)));

    // R8: no grant while a wait is running
    p_no_early_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w != '0) |-> !pd_grant_o);

endmodule

// File: tb/tb_pd_entry_guard.sv
module tb_pd_entry_guard;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cmd;
    logic [1:0] burst;
    logic [4:0] rl, wl, wr, tmod;
    logic [9:0] zq;
    logic       req;
    logic       grant;
    logic       cke;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pd_entry_guard dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .cfg_burst_i (burst),
        .cfg_rl_i    (rl),
        .cfg_wl_i    (wl),
        .cfg_wr_i    (wr),
        .cfg_tmod_i  (tmod),
        .cfg_zq_i    (zq),
        .pd_req_i    (req),
        .pd_grant_o  (grant),
        .cke_o       (cke)
    );

    typedef struct packed {
        logic [3:0] c;
        logic [1:0] b;
        logic [4:0] rl;
        logic [4:0] wl;
        logic [4:0] wr;
        logic [4:0] tmod;
        logic [9:0] zq;
        logic [7:0] expw;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd1},
        '{4'd3,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd1},
        '{4'd4,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd1},
        '{4'd5,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd16},
        '{4'd6,  2'd2, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd16},
        '{4'd10, 2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd16},
        '{4'd7,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd24},
        '{4'd7,  2'd1, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd24},
        '{4'd7,  2'd2, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd22},
        '{4'd7,  2'd3, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd24},
        '{4'd8,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd25},
        '{4'd8,  2'd1, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd25},
        '{4'd8,  2'd2, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd23},
        '{4'd9,  2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd12},
        '{4'd11, 2'd0, 5'd11, 5'd8, 5'd12, 5'd12, 10'd64, 8'd64},
        '{4'd5,  2'd0, 5'd5,  5'd5, 5'd5,  5'd7,  10'd30, 8'd10},
        '{4'd7,  2'd0, 5'd5,  5'd5, 5'd5,  5'd7,  10'd30, 8'd14},
        '{4'd8,  2'd2, 5'd5,  5'd5, 5'd5,  5'd7,  10'd30, 8'd13},
        '{4'd9,  2'd0, 5'd5,  5'd5, 5'd5,  5'd1,  10'd30, 8'd1}
    };

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd2, 4'd3, 4'd4:  return "R2";
            4'd5, 4'd6, 4'd10: return "R3";
            4'd7:              return "R4";
            4'd8:              return "R5";
            default:           return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Called just after a negedge with NOP and request already driven.
    task automatic wait_grant(input int start_k, output int k);
        bit held_high;
        held_high = 1'b1;
        k = start_k;
        while (!grant && k < 300) begin
            if (!cke) held_high = 1'b0;
            @(negedge clk);
            #1;
            k++;
        end
        chk(held_high, "R8", held_high, 1);
    endtask

    task automatic leave_pd();
        @(negedge clk);
        req = 1'b0;
        #1;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        rst_n = 1'b0;
        cmd   = 4'd0;
        burst = 2'd0;
        rl = 5'd11; wl = 5'd8; wr = 5'd12; tmod = 5'd12; zq = 10'd64;
        req   = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset holds clock-enable high even with the request up
        chk(cke == 1'b1, "R10", cke, 1);
        chk(grant == 1'b0, "R10", grant, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: nothing pending after reset, entry on the first idle slot
        chk(grant == 1'b1, "R10", grant, 1);
        leave_pd();

        // Vector table walk: measured wait per command
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            burst = VEC[i].b; rl = VEC[i].rl; wl = VEC[i].wl;
            wr = VEC[i].wr; tmod = VEC[i].tmod; zq = VEC[i].zq;
            cmd = VEC[i].c;
            req = 1'b0;
            @(negedge clk);
            cmd = 4'd0;
            req = 1'b1;
            #1;
            wait_grant(1, k);
            chk(k == int'(VEC[i].expw), req_of(VEC[i].c), k, int'(VEC[i].expw));
            chk(cke == 1'b0, "R1", cke, 0);
            leave_pd();
        end

        rl = 5'd11; wl = 5'd8; wr = 5'd12; tmod = 5'd12; zq = 10'd64; burst = 2'd0;

        // R1: a non-idle slot blocks entry even when the wait is over
        @(negedge clk);
        cmd = 4'd2;
        req = 1'b1;
        #1;
        chk(grant == 1'b0, "R1", grant, 0);
        chk(cke == 1'b1, "R1", cke, 1);
        @(negedge clk);
        cmd = 4'd1;
        #1;
        // R1: deselect slot carries entry
        chk(grant == 1'b1, "R1", grant, 1);
        chk(cke == 1'b0, "R1", cke, 0);
        // R9: held request keeps clock-enable low, no further grant
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            cmd = 4'd0;
            #1;
            chk(cke == 1'b0 && grant == 1'b0, "R9", cke, 0);
        end
        @(negedge clk);
        req = 1'b0;
        #1;
        // R9: dropping the request raises clock-enable at once
        chk(cke == 1'b1, "R9", cke, 1);
        @(negedge clk);
        #1;

        // R7: read then activate; activate must not cut the read wait
        @(negedge clk);
        cmd = 4'd5;
        req = 1'b1;
        @(negedge clk);
        cmd = 4'd2;
        #1;
        chk(grant == 1'b0, "R7", grant, 0);
        @(negedge clk);
        cmd = 4'd0;
        #1;
        wait_grant(2, k);
        chk(k == 16, "R7", k, 16);
        leave_pd();

        // R7: ZQ then mode-register set; longer ZQ wait survives
        @(negedge clk);
        cmd = 4'd11;
        req = 1'b0;
        @(negedge clk);
        cmd = 4'd9;
        @(negedge clk);
        cmd = 4'd0;
        req = 1'b1;
        #1;
        wait_grant(2, k);
        chk(k == 64, "R7", k, 64);
        leave_pd();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule